// File: doc/BRIEF.md
# Interleaved First-Order Recursive Filter

This block runs the recursion y[k] = x[k] + c·y[k−1] for several independent data streams while owning only one adder and one multiplier. The streams arrive up-sampled and interleaved: each clock cycle carries one sample of one stream, and the streams follow a fixed round-robin order 0, 1, …, N−1, 0, …. The clock therefore runs N times faster than the sample rate of any one stream.

No per-stream state memory exists. The adder stages, the multiplier stages and some extra balancing registers form a loop whose total delay is exactly N cycles. Each register in that loop holds the state of one stream. The scaled previous output of a stream comes back to the adder on the same cycle as that stream's next input sample. The coefficient is a signed fixed-point value. The multiplier output is rounded and then saturated, and the adder saturates instead of wrapping.

Top module: `ifr_top`

## Requirements
- R1: Each output is `sat(x + scale(c, yPrev))`, where `yPrev` is the previous output of the same stream and `scale` returns the product `c·yPrev` shifted right by `COEF_FRAC` bits. The coefficient is signed with `COEF_FRAC` fraction bits. With c = 0 the output equals the input.
- R2: Streams are independent. An input presented with index s only ever combines with the state of stream s. The loop delay is `NUM_STREAMS` cycles, made up of `ADD_LAT + MUL_LAT + (NUM_STREAMS − ADD_LAT − MUL_LAT)` balancing stages. Every valid output index lies below `NUM_STREAMS`.
- R3: The product is rounded to the nearest integer, with exact halves rounded toward +∞. For example, 1.5 becomes 2 and −1.5 becomes −1.
- R4: The scaled product and the final sum both saturate to the signed `DATA_W` range [−2^(DATA_W−1), 2^(DATA_W−1)−1]. Neither wraps.
- R5: A synchronous reset clears every loop register and every output. In the cycle after reset `outSample` is 0 and `outValid` is 0. After reset every stream starts from a state of zero.
- R6: `outValid` and `outIdx` equal `inValid` and `inIdx` delayed by exactly `ADD_LAT` cycles. `outSample` belongs to the same slot.
- R7: In a slot where `inValid` is 0, the input sample is replaced by zero. That stream's state still advances as c·yPrev, and the slot leaves with `outValid` = 0.
- R8: A sample entered before clock edge t appears on `outSample` after edge t + `ADD_LAT` − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, N times the per-stream sample rate |
| rst | input | 1 | Synchronous active-high reset |
| inSample | input | DATA_W | Signed input sample of the current slot |
| inValid | input | 1 | Input sample is genuine (otherwise treated as zero) |
| inIdx | input | $clog2(NUM_STREAMS) | Stream index of the current slot, round-robin |
| coef | input | COEF_W | Signed feedback coefficient, COEF_FRAC fraction bits |
| outSample | output | DATA_W | Signed filtered sample |
| outValid | output | 1 | Delayed copy of inValid |
| outIdx | output | $clog2(NUM_STREAMS) | Delayed copy of inIdx |

## Verification
The bench builds the block with six streams, a two-stage adder, a two-stage multiplier and therefore two balancing registers. This setup exercises a multi-cycle I/O delay and a populated balancing chain, and it keeps the interleave short enough that many recursion steps per stream fit in a short run. Narrow words (12-bit data, 10-bit coefficient with 8 fraction bits) let coefficients near 2.0 drive both the product and the sum into saturation within a few samples. The same narrow words make the exact half-way rounding cases easy to hit with small inputs.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic sampleEn;  // current slot carries a genuine sample
  } ifr_strobe_t;
endpackage

// File: rtl/ifr_ctrl.sv
module ifr_ctrl
  import ifr_pkg::*;
#(
  parameter int NUM_STREAMS = 16,
  parameter int ADD_LAT     = 1,
  localparam int IDX_W      = $clog2(NUM_STREAMS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [IDX_W-1:0] inIdx,
  output ifr_strobe_t      strobe,
  output logic             outValid,
  output logic [IDX_W-1:0] outIdx
);
  logic [IDX_W-1:0] idxPipe [ADD_LAT];
  logic             valPipe [ADD_LAT];

  always_comb strobe.sampleEn = inValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ADD_LAT; i++) begin
        idxPipe[i] <= '0;
        valPipe[i] <= 1'b0;
      end
    end else begin
      idxPipe[0] <= inIdx;
      valPipe[0] <= inValid;
      for (int i = 1; i < ADD_LAT; i++) begin
        idxPipe[i] <= idxPipe[i-1];
        valPipe[i] <= valPipe[i-1];
      end
    end
  end

  assign outIdx   = idxPipe[ADD_LAT-1];
  assign outValid = valPipe[ADD_LAT-1];
endmodule

// File: rtl/ifr_datapath.sv
module ifr_datapath
  import ifr_pkg::*;
#(
  parameter int NUM_STREAMS = 16,
  parameter int DATA_W      = 16,
  parameter int COEF_W      = 16,
  parameter int COEF_FRAC   = 14,
  parameter int ADD_LAT     = 1,
  parameter int MUL_LAT     = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ifr_strobe_t              strobe,
  input  logic signed [DATA_W-1:0] inSample,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [DATA_W-1:0] outSample
);
  localparam int BAL_LAT = NUM_STREAMS - ADD_LAT - MUL_LAT;
  localparam int PROD_W  = DATA_W + COEF_W;
  localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [PROD_W:0]   HALF  = (PROD_W+1)'(1) << (COEF_FRAC-1);

  logic signed [DATA_W-1:0] addPipe [ADD_LAT];
  logic signed [DATA_W-1:0] mulPipe [MUL_LAT];
  logic signed [DATA_W-1:0] fbVal, xGated, sumSat, prodSat, yCur;
  logic signed [DATA_W:0]   sumWide;
  logic signed [PROD_W-1:0] prodWide;
  logic signed [PROD_W:0]   prodRnd, prodShift;
  logic                     allZero, allOne;

  assign yCur = addPipe[ADD_LAT-1];

  // saturating adder
  always_comb begin
    xGated  = strobe.sampleEn ? inSample : '0;
    sumWide = {xGated[DATA_W-1], xGated} + {fbVal[DATA_W-1], fbVal};
    if (sumWide[DATA_W] != sumWide[DATA_W-1])
      sumSat = sumWide[DATA_W] ? MIN_V : MAX_V;
    else
      sumSat = sumWide[DATA_W-1:0];
  end

  // multiplier with round-half-up and saturation
  always_comb begin
    prodWide  = yCur * coef;
    prodRnd   = {prodWide[PROD_W-1], prodWide} + HALF;
    prodShift = prodRnd >>> COEF_FRAC;
    allZero   = ~|prodShift[PROD_W:DATA_W-1];
    allOne    = &prodShift[PROD_W:DATA_W-1];
    if (allZero || allOne) prodSat = prodShift[DATA_W-1:0];
    else                   prodSat = prodShift[PROD_W] ? MIN_V : MAX_V;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ADD_LAT; i++) addPipe[i] <= '0;
      for (int i = 0; i < MUL_LAT; i++) mulPipe[i] <= '0;
    end else begin
      addPipe[0] <= sumSat;
      for (int i = 1; i < ADD_LAT; i++) addPipe[i] <= addPipe[i-1];
      mulPipe[0] <= prodSat;
      for (int i = 1; i < MUL_LAT; i++) mulPipe[i] <= mulPipe[i-1];
    end
  end

  // balancing registers close the loop at NUM_STREAMS cycles
  generate
    if (BAL_LAT > 0) begin : g_bal
      logic signed [DATA_W-1:0] balPipe [BAL_LAT];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < BAL_LAT; i++) balPipe[i] <= '0;
        end else begin
          balPipe[0] <= mulPipe[MUL_LAT-1];
          for (int i = 1; i < BAL_LAT; i++) balPipe[i] <= balPipe[i-1];
        end
      end
      assign fbVal = balPipe[BAL_LAT-1];
    end else begin : g_nobal
      assign fbVal = mulPipe[MUL_LAT-1];
    end
  endgenerate

  assign outSample = yCur;
endmodule

// File: rtl/ifr_top.sv
module ifr_top
  import ifr_pkg::*;
#(
  parameter int NUM_STREAMS = 16,
  parameter int DATA_W      = 16,
  parameter int COEF_W      = 16,
  parameter int COEF_FRAC   = 14,
  parameter int ADD_LAT     = 1,
  parameter int MUL_LAT     = 2,
  localparam int IDX_W      = $clog2(NUM_STREAMS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] inSample,
  input  logic                     inValid,
  input  logic [IDX_W-1:0]         inIdx,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [DATA_W-1:0] outSample,
  output logic                     outValid,
  output logic [IDX_W-1:0]         outIdx
);
  ifr_strobe_t strobe;

  ifr_ctrl #(.NUM_STREAMS(NUM_STREAMS), .ADD_LAT(ADD_LAT)) i_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inIdx(inIdx),
    .strobe(strobe), .outValid(outValid), .outIdx(outIdx)
  );

  ifr_datapath #(
    .NUM_STREAMS(NUM_STREAMS), .DATA_W(DATA_W), .COEF_W(COEF_W),
    .COEF_FRAC(COEF_FRAC), .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)
  ) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .inSample(inSample),
    .coef(coef), .outSample(outSample)
  );
endmodule

// File: rtl/ifr_checker.sv
module ifr_checker #(
  parameter int NUM_STREAMS = 16,
  parameter int DATA_W      = 16,
  parameter int ADD_LAT     = 1,
  localparam int IDX_W      = $clog2(NUM_STREAMS)
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [IDX_W-1:0]  inIdx,
  input logic [DATA_W-1:0] outSample,
  input logic              outValid,
  input logic [IDX_W-1:0]  outIdx
);
  // independent delay reference for the slot tag
  logic [IDX_W-1:0] refIdx [ADD_LAT];
  logic             refVal [ADD_LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ADD_LAT; i++) begin
        refIdx[i] <= '0;
        refVal[i] <= 1'b0;
      end
    end else begin
      refIdx[0] <= inIdx;
      refVal[0] <= inValid;
      for (int i = 1; i < ADD_LAT; i++) begin
        refIdx[i] <= refIdx[i-1];
        refVal[i] <= refVal[i-1];
      end
    end
  end

  assert_idx_follow_R6: assert property (@(posedge clk) disable iff (rst)
    outIdx == refIdx[ADD_LAT-1]);

  assert_valid_follow_R6: assert property (@(posedge clk) disable iff (rst)
    outValid == refVal[ADD_LAT-1]);

  assert_idx_range_R2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (32'(outIdx) < NUM_STREAMS));

  assert_reset_clear_R5: assert property (@(posedge clk)
    rst |=> (outSample == '0 && !outValid));
endmodule

bind ifr_top ifr_checker #(
  .NUM_STREAMS(NUM_STREAMS), .DATA_W(DATA_W), .ADD_LAT(ADD_LAT)
) i_ifr_checker (
  .clk(clk), .rst(rst), .inValid(inValid), .inIdx(inIdx),
  .outSample(outSample), .outValid(outValid), .outIdx(outIdx)
);

// File: tb/test_ifr_top.sv
`timescale 1ns/1ps
module test_ifr_top;
  localparam int N   = 6;
  localparam int DW  = 12;
  localparam int CW  = 10;
  localparam int CF  = 8;
  localparam int AL  = 2;
  localparam int ML  = 2;
  localparam int IW  = $clog2(N);
  localparam int MAXV = (1 << (DW-1)) - 1;
  localparam int MINV = -(1 << (DW-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [DW-1:0] inSample = '0;
  logic inValid = 1'b0;
  logic [IW-1:0] inIdx = '0;
  logic signed [CW-1:0] coef = '0;
  logic signed [DW-1:0] outSample;
  logic outValid;
  logic [IW-1:0] outIdx;

  int checks = 0;
  int fails  = 0;

  int    yState [N];
  int    expY   [AL];
  logic  expV   [AL];
  int    expI   [AL];
  logic  expOk  [AL];
  string expTag [AL];
  int    rr = 0;
  int    coefNow = 0;

  always #2.5 clk = ~clk;

  ifr_top #(
    .NUM_STREAMS(N), .DATA_W(DW), .COEF_W(CW), .COEF_FRAC(CF),
    .ADD_LAT(AL), .MUL_LAT(ML)
  ) i_ifr_top (
    .clk(clk), .rst(rst), .inSample(inSample), .inValid(inValid),
    .inIdx(inIdx), .coef(coef), .outSample(outSample),
    .outValid(outValid), .outIdx(outIdx)
  );

  function automatic int satv(input longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return int'(v);
  endfunction

  function automatic int scaleRef(input int c, input int y);
    longint p = longint'(c) * longint'(y);
    return satv((p + (longint'(1) << (CF-1))) >>> CF);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock slot: check the due output, then drive the next sample
  task automatic slot(input int x, input logic v, input string tag);
    int xg, y;
    @(negedge clk);
    if (expOk[AL-1]) begin
      check({tag, " sample"}, int'(outSample), expY[AL-1]);
      check("R6 idx", int'(outIdx), expI[AL-1]);
      check("R6 valid", int'(outValid), int'(expV[AL-1]));
    end
    for (int i = AL-1; i > 0; i--) begin
      expY[i] = expY[i-1]; expV[i] = expV[i-1]; expI[i] = expI[i-1];
      expOk[i] = expOk[i-1]; expTag[i] = expTag[i-1];
    end
    xg = v ? x : 0;
    y  = satv(longint'(xg) + longint'(scaleRef(coefNow, yState[rr])));
    yState[rr] = y;
    expY[0] = y; expV[0] = v; expI[0] = rr; expOk[0] = 1'b1; expTag[0] = tag;
    inSample = DW'(x);
    inValid  = v;
    inIdx    = IW'(rr);
    rr = (rr + 1) % N;
  endtask

  task automatic restart(input int c);
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; inSample = '0; inIdx = '0;
    coef = CW'(c); coefNow = c;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < N; s++) yState[s] = 0;
    for (int i = 0; i < AL; i++) expOk[i] = 1'b0;
    rr = 0;
    check("R5 reset sample", int'(outSample), 0);
    check("R5 reset valid", int'(outValid), 0);
  endtask

  task automatic flush();
    for (int i = 0; i < AL; i++) slot(0, 1'b0, "R7 flush");
  endtask

  function automatic int rndX();
    return int'($urandom_range(0, (1 << DW) - 1)) + MINV;
  endfunction

  initial begin
    void'($urandom(32'd12345));
    for (int i = 0; i < AL; i++) expOk[i] = 1'b0;

    // c = 0: pass-through and latency (R1, R8)
    restart(0);
    for (int k = 0; k < 4*N; k++) slot(rndX(), 1'b1, "R1 R8 passthru");
    flush();

    // c = 0.5, random inputs, per-stream independence (R1, R2)
    restart(128);
    for (int k = 0; k < 20*N; k++) slot(rndX() / 4, 1'b1, "R2 random");
    flush();

    // half-way rounding: +1.5 -> 2, -1.5 -> -1 (R3)
    restart(128);
    for (int s = 0; s < N; s++) slot((s % 2) ? -3 : 3, 1'b1, "R3 seed");
    for (int s = 0; s < N; s++) slot(0, 1'b1, "R3 round");
    for (int s = 0; s < N; s++) slot(0, 1'b1, "R3 round2");
    flush();

    // saturation of sum (c=1.0) and product (c~1.99) (R4)
    restart(256);
    for (int k = 0; k < 4*N; k++) slot((rr % 2) ? MINV : MAXV, 1'b1, "R4 sum sat");
    flush();
    restart(511);
    for (int s = 0; s < N; s++) slot((s % 2) ? -1500 : 1500, 1'b1, "R4 seed");
    for (int k = 0; k < 3*N; k++) slot(0, 1'b1, "R4 prod sat");
    flush();

    // invalid slots inject zero and keep decaying (R7)
    restart(200);
    for (int k = 0; k < 20*N; k++) slot(rndX() / 2, 1'($urandom_range(0, 1)), "R7 gaps");
    flush();

    // mid-run reset clears state (R5)
    restart(-128);
    for (int k = 0; k < 5*N; k++) slot(rndX() / 2, 1'b1, "R1 negcoef");
    restart(-128);
    for (int k = 0; k < 2*N; k++) slot(rndX() / 2, 1'b1, "R5 after reset");
    flush();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule